// File: doc/BRIEF.md
# Byte-Stream Network Port Register Block

This block sits on a processor's 32-bit register bus and lets software move whole frames to and from a simple network device one byte at a time. Received frames come in on a byte-wide valid/ready input and are held in an internal FIFO. When the last byte of a frame arrives, the receive count is loaded with the frame length and a receive-available interrupt flag is set. Software then reads the receive data port repeatedly. Each read returns the next byte and lowers the count by one.

To send a frame, software writes the frame length into the transmit count and then writes that many bytes to the transmit data port. The bytes leave on a byte-wide valid/ready output, and the final byte is marked. When the device takes the final byte, the transmit count returns to 0 and a transmit-done flag is set.

The interrupt flags are cleared by writing 1 to them. A separate self-test flag is raised by software and clears when it is read. The interrupt line is the OR of the three flags. The bus window spans 0x40 bytes.

Top module: `bytenet_port`

## Requirements
- R1: Offset 0x00 reads 0x45545942 and offset 0x04 reads 0x31524F50. Together they form a 64-bit identifier of eight ASCII characters, with the first character in the least significant byte and a version digit ('1' by default) in the top byte.
- R2: Busy (offset 0x08, bit 0) reads 1 while a received frame is partly accepted, or while the transmit count is non-zero, and reads 0 otherwise.
- R3: When the byte marked last is accepted on the receive input, the receive count (offset 0x0C) becomes the number of bytes in that frame, and interrupt-control bit 1 is set.
- R4: A read of the receive data port (offset 0x1C) while the receive count is non-zero returns the next received byte in bits 7:0, with bits 31:8 zero, and lowers the count by one. When the count is 0, the port reads 0.
- R5: rx_ready is 0 while interrupt-control bit 1 is set or the receive count is non-zero, unless a frame is already partly accepted. This holds from the cycle after a frame's last byte.
- R6: After software writes N to the transmit count (offset 0x10) and writes N bytes to the transmit data port (offset 0x20, bits 7:0 only), those bytes leave on tx_data in order, and tx_last is 1 only on the Nth byte. Once the Nth byte is taken, the transmit count reads 0 and interrupt-control bit 0 is set.
- R7: Writing 1 to interrupt-control bit 0 or bit 1 (offset 0x14) clears that bit. Writing 0 to a bit leaves it unchanged.
- R8: Writing a value with bit 31 set raises test bit 31. The bit is cleared by a read of offset 0x14, or by writing the value 0 to offset 0x14.
- R9: irq is 1 exactly when any of interrupt-control bits 0, 1 or 31 is set.
- R10: Offset 0x18 reads the INFO_VALUE parameter (0x000000A5 by default). Writes to offsets 0x00 to 0x0C and to 0x18 have no effect. Offsets with no register read 0.
- R11: After reset, every counter and flag is 0, irq is 0, rx_ready is 1 and tx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; valid while bus_sel is 1 |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_ready | output | 1 | Receive byte accepted when valid |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Device takes the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds a frame on the receive input while the receive flag is set. A design that ignored the flag would silently swallow these bytes, and they would turn up in later reads. The bench also clears the flag before the frame has been read out. A design that checked only the flag, and not the remaining count, would then accept a new frame on top of unread data. The bench reads the data port at count 0, and reads interrupt control twice to catch a test bit that never self-clears. It sends a one-byte frame and a transmit frame under back-pressure. These catch a design that loads length minus one, or that clears the transmit count before the device has taken the last byte.

// File: rtl/bytenet_pkg.sv
package bytenet_pkg;
  localparam logic [5:0] OFF_ID_LO = 6'h00;
  localparam logic [5:0] OFF_ID_HI = 6'h04;
  localparam logic [5:0] OFF_BUSY  = 6'h08;
  localparam logic [5:0] OFF_RXCNT = 6'h0C;
  localparam logic [5:0] OFF_TXCNT = 6'h10;
  localparam logic [5:0] OFF_ICTL  = 6'h14;
  localparam logic [5:0] OFF_INFO  = 6'h18;
  localparam logic [5:0] OFF_RXDAT = 6'h1C;
  localparam logic [5:0] OFF_TXDAT = 6'h20;

  // seven-character name plus version; first character lands in byte 0
  function automatic logic [63:0] pack_id(input logic [55:0] name, input logic [7:0] ver);
    logic [63:0] w;
    w = '0;
    for (int i = 0; i < 7; i++) w[8*i +: 8] = name[8*(6-i) +: 8];
    w[63:56] = ver;
    return w;
  endfunction
endpackage

// File: rtl/bytenet_fifo.sv
module bytenet_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [OW-1:0] occ;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + OW'(1);
        2'b01:   occ <= occ - OW'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (occ == '0);
  assign full  = (occ == OW'(DEPTH));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/bytenet_irq.sv
module bytenet_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_tx,
  input  logic        set_rx,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] ictl,
  output logic        irq
);
  logic flag_tx, flag_rx, flag_test;
  logic clr_test_evt;

  assign clr_test_evt = rd_en || (wr_en && wdata == 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_tx   <= 1'b0;
      flag_rx   <= 1'b0;
      flag_test <= 1'b0;
    end else begin
      flag_tx <= set_tx || (flag_tx && !(wr_en && wdata[0]));
      flag_rx <= set_rx || (flag_rx && !(wr_en && wdata[1]));
      if (wr_en && wdata[31]) flag_test <= 1'b1;
      else if (clr_test_evt)  flag_test <= 1'b0;
    end
  end

  assign ictl = {flag_test, 29'b0, flag_rx, flag_tx};
  assign irq  = flag_tx || flag_rx || flag_test;

  // R6
  tx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) set_tx |=> flag_tx);
  // R7
  rx_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[1] && !set_rx) |=> !flag_rx);
  // R8
  test_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && flag_test) |=> !flag_test);
endmodule

// File: rtl/bytenet_port.sv
module bytenet_port #(
  parameter int unsigned MAX_FRAME  = 65536,
  parameter int unsigned RX_DEPTH   = 1024,
  parameter int unsigned TX_DEPTH   = 16,
  parameter logic [31:0] INFO_VALUE = 32'h0000_00A5,
  parameter logic [7:0]  ID_VER     = 8'h31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  import bytenet_pkg::*;

  localparam int unsigned CW      = $clog2(MAX_FRAME) + 1;
  localparam logic [63:0] ID_WORD = pack_id("BYTEPOR", ID_VER);

  function automatic logic [CW-1:0] clamp_len(input logic [31:0] v);
    return (v > 32'(MAX_FRAME)) ? CW'(MAX_FRAME) : v[CW-1:0];
  endfunction

  // bus decode events
  logic wr_evt, rd_evt, wr_txcnt, wr_txdat, wr_ictl, rd_ictl, rd_rxdat;
  assign wr_evt   = bus_sel && bus_wr;
  assign rd_evt   = bus_sel && !bus_wr;
  assign wr_txcnt = wr_evt && (bus_addr == OFF_TXCNT);
  assign wr_txdat = wr_evt && (bus_addr == OFF_TXDAT);
  assign wr_ictl  = wr_evt && (bus_addr == OFF_ICTL);
  assign rd_ictl  = rd_evt && (bus_addr == OFF_ICTL);
  assign rd_rxdat = rd_evt && (bus_addr == OFF_RXDAT);

  // receive side
  logic          rx_in_frame;
  logic [CW-1:0] rx_len, rx_cnt;
  logic          rxf_full, rxf_empty;
  logic [7:0]    rxf_dout;
  logic          rx_acc, rx_end_evt, rx_pop_evt;
  logic [31:0]   ictl_val;

  assign rx_ready   = !rxf_full && (rx_in_frame || (rx_cnt == '0 && !ictl_val[1]));
  assign rx_acc     = rx_valid && rx_ready;
  assign rx_end_evt = rx_acc && rx_last;
  assign rx_pop_evt = rd_rxdat && (rx_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_in_frame <= 1'b0;
      rx_len      <= '0;
      rx_cnt      <= '0;
    end else if (rx_acc) begin
      rx_in_frame <= !rx_last;
      rx_len      <= rx_last ? '0 : rx_len + CW'(1);
      if (rx_last) rx_cnt <= rx_len + CW'(1);
    end else if (rx_pop_evt) begin
      rx_cnt <= rx_cnt - CW'(1);
    end
  end

  bytenet_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_acc), .din(rx_data), .pop(rx_pop_evt),
    .dout(rxf_dout), .empty(rxf_empty), .full(rxf_full)
  );

  // transmit side
  logic [CW-1:0] tx_cnt, tx_left;
  logic          txf_full, txf_empty;
  logic [8:0]    txf_dout;
  logic          tx_push_evt, tx_pop_evt, tx_done_evt;

  assign tx_push_evt = wr_txdat && (tx_left != '0) && !txf_full;
  assign tx_valid    = !txf_empty;
  assign tx_data     = txf_dout[7:0];
  assign tx_last     = txf_dout[8] && tx_valid;
  assign tx_pop_evt  = tx_valid && tx_ready;
  assign tx_done_evt = tx_pop_evt && txf_dout[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt  <= '0;
      tx_left <= '0;
    end else if (wr_txcnt) begin
      tx_cnt  <= clamp_len(bus_wdata);
      tx_left <= clamp_len(bus_wdata);
    end else begin
      if (tx_push_evt) tx_left <= tx_left - CW'(1);
      if (tx_done_evt) tx_cnt  <= '0;
    end
  end

  bytenet_fifo #(.W(9), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_push_evt),
    .din({tx_left == CW'(1), bus_wdata[7:0]}), .pop(tx_pop_evt),
    .dout(txf_dout), .empty(txf_empty), .full(txf_full)
  );

  // interrupts
  bytenet_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_tx(tx_done_evt), .set_rx(rx_end_evt),
    .wr_en(wr_ictl), .rd_en(rd_ictl), .wdata(bus_wdata), .ictl(ictl_val), .irq(irq)
  );

  // read mux
  logic busy;
  assign busy = rx_in_frame || (tx_cnt != '0);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        OFF_ID_LO: bus_rdata = ID_WORD[31:0];
        OFF_ID_HI: bus_rdata = ID_WORD[63:32];
        OFF_BUSY:  bus_rdata = {31'b0, busy};
        OFF_RXCNT: bus_rdata = 32'(rx_cnt);
        OFF_TXCNT: bus_rdata = 32'(tx_cnt);
        OFF_ICTL:  bus_rdata = ictl_val;
        OFF_INFO:  bus_rdata = INFO_VALUE;
        OFF_RXDAT: bus_rdata = (rx_cnt != '0) ? {24'b0, rxf_dout} : 32'b0;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R3
  rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end_evt |=> (rx_cnt == $past(rx_len) + CW'(1)) && ictl_val[1]);
  // R4
  rx_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_evt |=> rx_cnt == $past(rx_cnt) - CW'(1));
  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end_evt |=> !rx_ready);
  // R6
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_evt && !wr_txcnt) |=> tx_cnt == '0);
endmodule

// File: tb/bytenet_port_bench.sv
module bytenet_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  logic [7:0] rx_q [$];
  logic [8:0] tx_q [$];

  always #5 clk = ~clk;

  bytenet_port u_bytenet_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic bw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    br(a, d);
    chk(req, d, exp);
  endtask

  // receive driver: scoreboard gets every byte offered
  task automatic rx_send(input int n, input logic [7:0] base, input bit end_frame);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      rx_valid = 1'b1; rx_data = base + 8'(i);
      rx_last = end_frame && (i == n - 1);
      rx_q.push_back(rx_data);
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_last = 1'b0;
    end
  endtask

  // reads of the data port are compared against the scoreboard (R4)
  task automatic rx_read_one(input int cnt_after);
    logic [31:0] d;
    logic [7:0]  e;
    br(6'h1C, d);
    e = (rx_q.size() > 0) ? rx_q.pop_front() : 8'h00;
    chk("R4 rx byte", d, {24'b0, e});
    rd_chk("R4 rx count", 6'h0C, 32'(cnt_after));
  endtask

  // transmit driver
  task automatic tx_send(input int n, input logic [7:0] base);
    bw(6'h10, 32'(n));
    for (int i = 0; i < n; i++) begin
      bw(6'h20, {24'hC0FFEE, base + 8'(i)});
      tx_q.push_back({(i == n - 1), base + 8'(i)});
    end
  endtask

  // transmit monitor
  always begin
    @(negedge clk); #2;
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_q.size() == 0) chk("R6 unexpected tx byte", {23'b0, tx_last, tx_data}, 32'hFFFF_FFFF);
      else chk("R6 tx byte/last", {23'b0, tx_last, tx_data}, {23'b0, tx_q.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 0);
    chk("R11 rx_ready", {31'b0, rx_ready}, 1);
    chk("R11 tx_valid", {31'b0, tx_valid}, 0);
    rd_chk("R11 busy", 6'h08, 0);
    rd_chk("R11 rxcnt", 6'h0C, 0);
    rd_chk("R11 txcnt", 6'h10, 0);
    rd_chk("R11 ictl", 6'h14, 0);

    // R1 identifier
    rd_chk("R1 id low", 6'h00, 32'h4554_5942);
    rd_chk("R1 id high", 6'h04, 32'h3152_4F50);

    // R10 fixed info, ignored writes, empty offsets
    rd_chk("R10 info", 6'h18, 32'h0000_00A5);
    bw(6'h18, 32'hFFFF_FFFF);
    rd_chk("R10 info after write", 6'h18, 32'h0000_00A5);
    bw(6'h0C, 32'd7);
    rd_chk("R10 rxcnt write ignored", 6'h0C, 0);
    bw(6'h08, 32'd1);
    rd_chk("R10 busy write ignored", 6'h08, 0);
    bw(6'h00, 32'h1234_5678);
    rd_chk("R10 id write ignored", 6'h00, 32'h4554_5942);
    rd_chk("R10 empty 0x24", 6'h24, 0);
    rd_chk("R10 empty 0x3C", 6'h3C, 0);

    // R2 busy during a partly received frame
    rx_send(2, 8'h10, 1'b0);
    rd_chk("R2 busy mid-frame", 6'h08, 1);
    rx_send(2, 8'h12, 1'b1);
    // R3 length and flag
    rd_chk("R3 rx count", 6'h0C, 4);
    rd_chk("R3 ictl rx flag", 6'h14, 32'h2);
    chk("R9 irq on rx flag", {31'b0, irq}, 1);
    rd_chk("R2 busy idle", 6'h08, 0);

    // R5 further frames held off
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R5 ready low with flag", {31'b0, rx_ready}, 0);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    // R7 clear rx flag; count still pending keeps input closed
    bw(6'h14, 32'h2);
    rd_chk("R7 rx flag cleared", 6'h14, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
    @(negedge clk); #1;
    chk("R5 ready low with count", {31'b0, rx_ready}, 0);
    rx_read_one(3);
    rx_read_one(2);
    rx_read_one(1);
    rx_read_one(0);
    rd_chk("R4 empty port", 6'h1C, 0);
    @(negedge clk); #1;
    chk("R5 ready back", {31'b0, rx_ready}, 1);

    // one-byte frame boundary
    rx_send(1, 8'hA7, 1'b1);
    rd_chk("R3 one-byte count", 6'h0C, 1);
    rx_read_one(0);
    bw(6'h14, 32'h2);

    // R6 transmit with the sink ready
    tx_ready = 1'b1;
    bw(6'h10, 32'd3);
    rd_chk("R2 busy tx pending", 6'h08, 1);
    for (int i = 0; i < 3; i++) begin
      bw(6'h20, {24'hABCDEF, 8'h50 + 8'(i)});
      tx_q.push_back({(i == 2), 8'h50 + 8'(i)});
    end
    repeat (4) @(negedge clk);
    rd_chk("R6 tx count cleared", 6'h10, 0);
    rd_chk("R6 tx done flag", 6'h14, 32'h1);
    chk("R9 irq on tx flag", {31'b0, irq}, 1);
    bw(6'h14, 32'h1);
    rd_chk("R7 tx flag cleared", 6'h14, 0);

    // R6 transmit under back-pressure
    @(negedge clk); tx_ready = 1'b0;
    tx_send(2, 8'h61);
    repeat (3) @(negedge clk);
    #1 chk("R6 tx_valid held", {31'b0, tx_valid}, 1);
    rd_chk("R6 count held", 6'h10, 2);
    rd_chk("R6 no done yet", 6'h14, 0);
    @(negedge clk); tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R6 count after drain", 6'h10, 0);
    chk("R6 scoreboard empty", 32'(tx_q.size()), 0);
    bw(6'h14, 32'h1);

    // R8 test bit
    bw(6'h14, 32'h8000_0000);
    chk("R9 irq on test", {31'b0, irq}, 1);
    rd_chk("R8 test set", 6'h14, 32'h8000_0000);
    rd_chk("R8 test read-cleared", 6'h14, 0);
    chk("R9 irq after test", {31'b0, irq}, 0);
    bw(6'h14, 32'h8000_0000);
    bw(6'h14, 32'h0);
    chk("R8 zero write clears", {31'b0, irq}, 0);
    rd_chk("R8 ictl after zero", 6'h14, 0);

    finish_run();
  end
endmodule